// File: doc/BRIEF.md
# Cascadable 8/16-bit Match Timer Pair

The block holds two 8-bit up-counters. Each has its own compare value, clock-source select, start control and pause control. Left alone, each counter is an independent periodic timer. It counts one step per selected tick, returns to zero on the tick after it reaches its compare value, and pulses its interrupt output on that wrapping tick.

When the chain bit is set and the upper timer's source select is all ones, the two counters act as one 16-bit timer. The lower counter is the low byte and the upper counter is the high byte. The 16-bit count is clocked by the lower timer's source and compared against the two compare bytes joined together. It is governed by the lower timer's start and pause controls. Its match interrupt appears on the lower timer's interrupt output.

All count sources are single-cycle enables in the system clock domain. Internal sources come in as prescaled tick pulses. The external event pin is synchronised and edge-detected inside the block.

Top module: `cascade_timer_pair`

## Requirements
- R1: While running, a counter advances by exactly one on each selected tick. It returns to zero on the tick that finds it equal to its compare value, so one period is compare+1 ticks.
- R2: The interrupt pulse lasts exactly one clock cycle. It is high in the cycle after the wrapping tick is sampled, and in that cycle the count already reads zero.
- R3: The lower select is a 3-bit field. Values 0 to 6 pick `int_tick[lo_sel]` and value 7 picks the rising edge of `ext_evt`. Ticks on unselected sources leave the count unchanged.
- R4: The upper select is a 2-bit field. Values 0 to 2 pick `int_tick[hi_sel]` and value 3 picks the rising edge of `ext_evt` (in independent mode only).
- R5: 16-bit mode holds only when `chain_mode`=1 and `hi_sel`=3. In that mode:
  - `{hi_count, lo_count}` counts on the lower source and wraps after `{hi_cmp, lo_cmp}`.
  - The interrupt appears on `lo_irq` and `hi_irq` stays 0.
  - `hi_start` and `hi_run` have no effect.
  - With `chain_mode`=1 and any other `hi_sel`, the timers stay independent.
- R6: A start input at 0 forces its count to zero and stops it. At 1 the counter runs from zero.
- R7: A run input at 0 holds the count at its present value while ticks arrive. Returning it to 1 resumes counting from the held value.
- R8: In independent mode the two timers keep separate counts, compares and interrupts, even when they are fed the same tick source.
- R9: The external event is counted once per rising edge, however long it stays high. The count changes on the third clock edge after `ext_evt` rises.
- R10: Asynchronous active-low reset clears both counts and both interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_tick | input | 7 | Prescaled internal tick enables, one cycle each |
| ext_evt | input | 1 | External event pin, asynchronous |
| chain_mode | input | 1 | Request to join the timers into one 16-bit timer |
| lo_sel | input | 3 | Lower timer source select |
| hi_sel | input | 2 | Upper timer source select |
| lo_start | input | 1 | Lower start: 0 clears and stops, 1 runs |
| lo_run | input | 1 | Lower pause control: 0 holds, 1 counts |
| hi_start | input | 1 | Upper start: 0 clears and stops, 1 runs |
| hi_run | input | 1 | Upper pause control: 0 holds, 1 counts |
| lo_cmp | input | 8 | Lower compare value |
| hi_cmp | input | 8 | Upper compare value |
| lo_irq | output | 1 | Lower (or 16-bit) match interrupt pulse |
| hi_irq | output | 1 | Upper match interrupt pulse |
| lo_count | output | 8 | Lower count value |
| hi_count | output | 8 | Upper count value |

## Verification
The step assertion tolerates a count that runs past a lowered compare value and wraps through all ones. It therefore takes for granted only that compare values, mode and selects are quiet in the cycles where they matter. The stimulus changes those values only while the affected counters are stopped or between tests.

`ext_evt` is treated as fully asynchronous, but the bench drives it away from clock edges. The bench holds each level for several cycles so that edge counting is deterministic.

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    int_tick,
  input  logic          ext_evt,
  input  logic          chain_mode,
  input  logic [2:0]    lo_sel,
  input  logic [1:0]    hi_sel,
  input  logic          lo_start,
  input  logic          lo_run,
  input  logic          hi_start,
  input  logic          hi_run,
  input  logic [CW-1:0] lo_cmp,
  input  logic [CW-1:0] hi_cmp,
  output logic          lo_irq,
  output logic          hi_irq,
  output logic [CW-1:0] lo_count,
  output logic [CW-1:0] hi_count
);

  logic ext_s1, ext_s2, ext_d;
  logic ext_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ext_s1, ext_s2, ext_d} <= '0;
    else        {ext_s1, ext_s2, ext_d} <= {ext_evt, ext_s1, ext_s2};

  assign ext_edge = ext_s2 & ~ext_d;

  logic [7:0] lo_src;
  logic [3:0] hi_src;
  logic       lo_tick, hi_tick;

  assign lo_src  = {ext_edge, int_tick};
  assign hi_src  = {ext_edge, int_tick[2:0]};
  assign lo_tick = lo_src[lo_sel];
  assign hi_tick = hi_src[hi_sel];

  logic chained;
  logic lo_adv, hi_adv_own;
  logic lo_match, hi_match, lo_wrap, hi_go;

  assign chained    = chain_mode && (hi_sel == 2'b11);
  assign lo_adv     = lo_start && lo_run && lo_tick;
  assign hi_adv_own = hi_start && hi_run && hi_tick;
  assign lo_match   = (lo_count == lo_cmp);
  assign hi_match   = (hi_count == hi_cmp);
  assign lo_wrap    = chained ? (lo_match && hi_match) : lo_match;
  assign hi_go      = chained ? lo_start : hi_start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_count <= '0;
      lo_irq   <= 1'b0;
    end else begin
      lo_irq <= lo_adv && lo_wrap;
      if (!lo_start)   lo_count <= '0;
      else if (lo_adv) lo_count <= lo_wrap ? '0 : lo_count + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_count <= '0;
      hi_irq   <= 1'b0;
    end else begin
      hi_irq <= !chained && hi_adv_own && hi_match;
      if (!hi_go)
        hi_count <= '0;
      else if (chained) begin
        if (lo_adv) begin
          if (lo_wrap)            hi_count <= '0;
          else if (&lo_count)     hi_count <= hi_count + 1'b1;
        end
      end else if (hi_adv_own)
        hi_count <= hi_match ? '0 : hi_count + 1'b1;
    end

  // R2: an interrupt cycle always shows the wrapped count
  a_r2_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lo_irq |-> (lo_count == '0));

  // R5: upper interrupt silent while chained
  a_r5_hi_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    chained |=> !hi_irq);

  // R6: stopped counters read zero
  a_r6_lo_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_start |=> (lo_count == '0));
  a_r6_hi_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_start && !chained) |=> (hi_count == '0));

  // R7: pause holds value
  a_r7_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_start && !lo_run) |=> $stable(lo_count));

  // R1: running count only steps by one or wraps to zero
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    lo_start |=> (lo_count == $past(lo_count) || lo_count == '0
                  || lo_count == $past(lo_count) + 1'b1));

endmodule

// File: tb/cascade_timer_pair_tb_top.sv
module cascade_timer_pair_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] int_tick = '0;
  logic ext_evt = 1'b0, chain_mode = 1'b0;
  logic [2:0] lo_sel = '0;
  logic [1:0] hi_sel = '0;
  logic lo_start = 1'b0, lo_run = 1'b0, hi_start = 1'b0, hi_run = 1'b0;
  logic [7:0] lo_cmp = '0, hi_cmp = '0;
  logic lo_irq, hi_irq;
  logic [7:0] lo_count, hi_count;

  int nvec = 0, nbad = 0;
  int lo_irqs = 0, hi_irqs = 0;

  always #(CLK_P/2) clk = ~clk;

  cascade_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_evt(ext_evt),
    .chain_mode(chain_mode), .lo_sel(lo_sel), .hi_sel(hi_sel),
    .lo_start(lo_start), .lo_run(lo_run), .hi_start(hi_start), .hi_run(hi_run),
    .lo_cmp(lo_cmp), .hi_cmp(hi_cmp), .lo_irq(lo_irq), .hi_irq(hi_irq),
    .lo_count(lo_count), .hi_count(hi_count));

  always @(negedge clk) begin
    if (lo_irq) lo_irqs++;
    if (hi_irq) hi_irqs++;
  end

  // {cmp, ticks, expected count, expected interrupts}
  localparam logic [31:0] VEC [8] = '{
    {8'd5,   8'd3,  8'd3,  8'd0},
    {8'd5,   8'd6,  8'd0,  8'd1},
    {8'd5,   8'd13, 8'd1,  8'd2},
    {8'd0,   8'd4,  8'd0,  8'd4},
    {8'd255, 8'd10, 8'd10, 8'd0},
    {8'd2,   8'd9,  8'd0,  8'd3},
    {8'd3,   8'd10, 8'd2,  8'd2},
    {8'd1,   8'd1,  8'd1,  8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int idx, input int n);
    @(negedge clk) int_tick[idx] = 1'b1;
    repeat (n) @(negedge clk);
    int_tick[idx] = 1'b0;
    @(negedge clk);
  endtask

  task automatic restart_lo();
    @(negedge clk) lo_start = 1'b0;
    @(negedge clk) lo_start = 1'b1; lo_run = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int base, hbase;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 lo_count", lo_count, 0);
    check("R10 hi_count", hi_count, 0);
    check("R10 irqs", lo_irq + hi_irq, 0);
    rst_n = 1'b1;

    // R1 table
    for (int i = 0; i < 8; i++) begin
      lo_cmp = VEC[i][31:24];
      restart_lo();
      base = lo_irqs;
      ticks(0, VEC[i][23:16]);
      check("R1 count", lo_count, VEC[i][15:8]);
      check("R1 irq count", lo_irqs - base, VEC[i][7:0]);
    end

    // R2: pulse width and alignment
    lo_cmp = 8'd1;
    restart_lo();
    ticks(0, 1);
    @(negedge clk) int_tick[0] = 1'b1;
    @(negedge clk) int_tick[0] = 1'b0;
    check("R2 irq high", lo_irq, 1);
    check("R2 count zero with irq", lo_count, 0);
    @(negedge clk);
    check("R2 irq one cycle", lo_irq, 0);

    // R3: source selection
    lo_cmp = 8'd200;
    lo_sel = 3'd4;
    restart_lo();
    ticks(0, 3);
    check("R3 unselected ignored", lo_count, 0);
    ticks(4, 3);
    check("R3 int_tick[4] counted", lo_count, 3);

    // R9 and R3: external edge, sel 7
    lo_sel = 3'd7;
    restart_lo();
    @(negedge clk) ext_evt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 not yet counted", lo_count, 0);
    @(negedge clk);
    check("R9 counted on third edge", lo_count, 1);
    repeat (8) @(negedge clk);
    check("R9 one count per edge", lo_count, 1);
    ext_evt = 1'b0;
    repeat (3) @(negedge clk);
    ext_evt = 1'b1;
    repeat (5) @(negedge clk);
    ext_evt = 1'b0;
    check("R3 ext sel 7 second edge", lo_count, 2);

    // R6: start clears and stops
    lo_sel = 3'd0;
    restart_lo();
    ticks(0, 3);
    @(negedge clk) lo_start = 1'b0;
    @(negedge clk);
    check("R6 stop clears", lo_count, 0);
    ticks(0, 4);
    check("R6 stopped ignores ticks", lo_count, 0);
    lo_start = 1'b1;
    ticks(0, 2);
    check("R6 restart from zero", lo_count, 2);

    // R7: pause holds
    lo_run = 1'b0;
    ticks(0, 5);
    check("R7 paused holds", lo_count, 2);
    lo_run = 1'b1;
    ticks(0, 3);
    check("R7 resumes from held", lo_count, 5);

    // R4 and R8: independent timers on shared source
    lo_cmp = 8'd2; hi_cmp = 8'd4; hi_sel = 2'd0;
    restart_lo();
    @(negedge clk) hi_start = 1'b1; hi_run = 1'b1;
    base = lo_irqs; hbase = hi_irqs;
    ticks(0, 7);
    check("R8 lo count", lo_count, 1);
    check("R8 hi count", hi_count, 2);
    check("R8 lo irqs", lo_irqs - base, 2);
    check("R8 hi irqs", hi_irqs - hbase, 1);
    @(negedge clk) hi_start = 1'b0;
    @(negedge clk) hi_start = 1'b1; hi_sel = 2'd2;
    ticks(1, 3);
    check("R4 hi_sel 2 ignores tick1", hi_count, 0);
    ticks(2, 3);
    check("R4 hi_sel 2 counts tick2", hi_count, 3);

    // R5: chain bit without hi_sel 3 stays independent
    chain_mode = 1'b1; hi_sel = 2'd2; lo_cmp = 8'd2;
    restart_lo();
    ticks(0, 4);
    check("R5 no chain without sel3", lo_count, 1);

    // R5: 16-bit mode, hi controls ignored
    hi_start = 1'b0; hi_run = 1'b0;
    hi_sel = 2'd3; hi_cmp = 8'd1; lo_cmp = 8'd2;
    restart_lo();
    base = lo_irqs; hbase = hi_irqs;
    ticks(0, 258);
    check("R5 chained low byte", lo_count, 2);
    check("R5 chained high byte", hi_count, 1);
    check("R5 no early irq", lo_irqs - base, 0);
    ticks(0, 1);
    check("R5 wrap low", lo_count, 0);
    check("R5 wrap high", hi_count, 0);
    check("R5 irq on lower", lo_irqs - base, 1);
    check("R5 upper irq silent", hi_irqs - hbase, 0);

    // R10: mid-run reset
    ticks(0, 300);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R10 async clear lo", lo_count, 0);
    check("R10 async clear hi", hi_count, 0);
    rst_n = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule